// File: doc/BRIEF.md
# Battery-Less PC Clock/Calendar with Serially Backed Configuration RAM

This block reproduces the programming model of the classic PC clock/calendar chip on an 8-bit I/O interface. Software writes a register number into an index port and then reads or writes the selected register through a data port. Six binary counters keep seconds, minutes, hours, day, month and year. A one-pulse-per-second tick advances them. The tick comes from dividing the strobes of the system timer's reference clock by an exact integer.

Alongside the calendar sits a small byte-wide configuration RAM that software sees through a window of indices. The RAM does not keep its contents without power. Instead, an external microcontroller copies the RAM out, and writes it back at power-on, over a two-line serial link made of one clock line and one data line. Both lines are sampled through synchronisers in the block's clock domain. Each frame has three parts, in this order: a direction bit, a 5-bit byte address, and 8 data bits.

Top module: `cmos_rtc_nv`

## Requirements
- R1: `io_addr`=0 selects the index port. A write there stores `io_wdata` as the current index, and a read there returns the stored index.
- R2: `io_addr`=1 selects the data port. The time registers sit at index 0x00 (seconds), 0x02 (minutes), 0x04 (hours), 0x07 (day of month), 0x08 (month) and 0x09 (year). A data-port write loads the selected counter. A read returns its value in binary, zero-extended to 8 bits. Read data appears on `io_rdata` at the clock edge that samples `io_rd` and holds until the next read.
- R3: The counters advance by exactly one second on every `DIV_COUNT`-th cycle in which `tmr_ref_en` is high. Without such a tick and without a write, the counters do not change.
- R4: Seconds and minutes wrap from 59 to 0, and each wrap carries into the next field. Hours wrap from 23 to 0 and carry into the day.
- R5: The day wraps to 1 after the last day of its month, and the month then advances. April, June, September and November have 30 days. February has 29 days when the year is divisible by 4 and 28 days otherwise. All other months have 31 days.
- R6: After 23:59:59 on day 31 of month 12, the month becomes 1 and the year advances. Year 99 wraps to 0.
- R7: The configuration RAM holds 32 bytes. Byte k is reached through data-port index 0x10+k.
- R8: A data-port read at an index that is neither a time register nor in the RAM window returns 0x00. A data-port write at such an index changes nothing.
- R9: A link frame is made of 14 bits, each sampled on a rising edge of `lnk_clk`. It starts with a direction bit, then the address MSB first, then the data MSB first. A direction bit of 1 stores the data byte into RAM at the given address.
- R10: A direction bit of 0 makes the block drive the addressed byte onto `lnk_dat_o`. Bit 7 appears after the sixth rising edge, and the output moves on to the next lower bit after each later rising edge. Outside the data phase of a read frame, `lnk_dat_o` is 1.
- R11: If no rising edge arrives on `lnk_clk` for `LINK_IDLE` clock cycles, a partly received frame is discarded and the next bit starts a new frame.
- R12: After reset, the time reads 00:00:00 on day 1 of month 1 of year 0, the index is 0x00, and every RAM byte is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tmr_ref_en | input | 1 | One-cycle strobe per period of the timer reference clock |
| io_addr | input | 1 | Port select: 0 index, 1 data |
| io_rd | input | 1 | Read strobe |
| io_wr | input | 1 | Write strobe |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Registered read data |
| lnk_clk | input | 1 | Serial link clock from the external controller |
| lnk_dat_i | input | 1 | Serial link data from the controller |
| lnk_dat_o | output | 1 | Serial link data to the controller |

## Verification
The bench goes after the calendar edges: the wrap at the end of the century, February in leap and common years, the 30-day months, and the hour carry. A design that got one of these wrong would show a day 29, 31 or 0 that should not exist, or would fail to advance the month or year. It compares random legal dates, advanced by random numbers of strobes, against a bench model, so a divider that is off by one strobe shows up as a second gained or lost. On the link side it sends full frames in both directions, and a frame cut short by an idle gap. A receiver that kept stale bits after the gap would store the following frame's byte at a wrong address. It also checks indices just outside the RAM window, where a decoder that is off by one would alias onto RAM.

// File: rtl/cmos_rtc_pkg.sv
package cmos_rtc_pkg;

   typedef enum logic [2:0] {
      FLD_NONE,
      FLD_SEC,
      FLD_MIN,
      FLD_HOUR,
      FLD_DAY,
      FLD_MON,
      FLD_YEAR
   } time_field_e;

   localparam logic [7:0] IDX_SEC  = 8'h00;
   localparam logic [7:0] IDX_MIN  = 8'h02;
   localparam logic [7:0] IDX_HOUR = 8'h04;
   localparam logic [7:0] IDX_DAY  = 8'h07;
   localparam logic [7:0] IDX_MON  = 8'h08;
   localparam logic [7:0] IDX_YEAR = 8'h09;

   typedef struct packed {
      logic [6:0] year;
      logic [3:0] mon;
      logic [4:0] day;
      logic [4:0] hour;
      logic [5:0] min;
      logic [5:0] sec;
   } rtc_time_t;

   function automatic logic [4:0] month_days(input logic [3:0] mon, input logic leap);
      logic [4:0] d;
      case (mon)
         4'd2:                    d = leap ? 5'd29 : 5'd28;
         4'd4, 4'd6, 4'd9, 4'd11: d = 5'd30;
         default:                 d = 5'd31;
      endcase
      return d;
   endfunction

endpackage

// File: rtl/cmos_tick_div.sv
module cmos_tick_div #(
   parameter int unsigned DIV_COUNT = 1193182
) (
   input  logic clk,
   input  logic rst_n,
   input  logic ref_en,
   output logic tick
);
   localparam int unsigned CW = (DIV_COUNT > 1) ? $clog2(DIV_COUNT) : 1;

   if (DIV_COUNT < 2) begin : g_bad_div
      $error("cmos_tick_div: DIV_COUNT must be at least 2");
   end

   logic [CW-1:0] cnt;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt  <= '0;
         tick <= 1'b0;
      end else begin
         tick <= 1'b0;
         if (ref_en) begin
            if (cnt == CW'(DIV_COUNT - 1)) begin
               cnt  <= '0;
               tick <= 1'b1;
            end else begin
               cnt <= cnt + 1'b1;
            end
         end
      end
   end

   AST_TICK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      tick |=> !tick); // R3
   AST_TICK_FROM_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(tick) |-> $past(ref_en)); // R3

endmodule

// File: rtl/cmos_time_keeper.sv
module cmos_time_keeper
   import cmos_rtc_pkg::*;
#(
   parameter bit LEAP_EVERY_4 = 1'b1
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        tick,
   input  time_field_e wr_sel,
   input  logic [7:0]  wr_val,
   output rtc_time_t   now
);
   localparam logic [5:0] SEC_LAST  = 6'd59;
   localparam logic [5:0] MIN_LAST  = 6'd59;
   localparam logic [4:0] HOUR_LAST = 5'd23;
   localparam logic [3:0] MON_LAST  = 4'd12;
   localparam logic [6:0] YEAR_LAST = 7'd99;

   logic       is_leap;
   logic [4:0] last_day;

   if (LEAP_EVERY_4) begin : g_leap4
      assign is_leap = (now.year[1:0] == 2'b00);
   end else begin : g_noleap
      assign is_leap = 1'b0;
   end

   assign last_day = month_days(now.mon, is_leap);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         now.sec  <= '0;
         now.min  <= '0;
         now.hour <= '0;
         now.day  <= 5'd1;
         now.mon  <= 4'd1;
         now.year <= '0;
      end else if (wr_sel != FLD_NONE) begin
         case (wr_sel)
            FLD_SEC:  now.sec  <= wr_val[5:0];
            FLD_MIN:  now.min  <= wr_val[5:0];
            FLD_HOUR: now.hour <= wr_val[4:0];
            FLD_DAY:  now.day  <= wr_val[4:0];
            FLD_MON:  now.mon  <= wr_val[3:0];
            FLD_YEAR: now.year <= wr_val[6:0];
            default:  ;
         endcase
      end else if (tick) begin
         if (now.sec >= SEC_LAST) begin
            now.sec <= '0;
            if (now.min >= MIN_LAST) begin
               now.min <= '0;
               if (now.hour >= HOUR_LAST) begin
                  now.hour <= '0;
                  if (now.day >= last_day) begin
                     now.day <= 5'd1;
                     if (now.mon >= MON_LAST) begin
                        now.mon  <= 4'd1;
                        now.year <= (now.year >= YEAR_LAST) ? 7'd0 : now.year + 7'd1;
                     end else begin
                        now.mon <= now.mon + 4'd1;
                     end
                  end else begin
                     now.day <= now.day + 5'd1;
                  end
               end else begin
                  now.hour <= now.hour + 5'd1;
               end
            end else begin
               now.min <= now.min + 6'd1;
            end
         end else begin
            now.sec <= now.sec + 6'd1;
         end
      end
   end

   AST_SEC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && wr_sel == FLD_NONE) |=> (now.sec == $past(now.sec) + 6'd1) || (now.sec == 6'd0)); // R4
   AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick && wr_sel == FLD_NONE) |=> $stable(now)); // R3
   AST_YEAR_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && wr_sel == FLD_NONE && now.year == 7'd99 && now.mon == 4'd12 && now.day == 5'd31
       && now.hour == 5'd23 && now.min == 6'd59 && now.sec == 6'd59) |=> (now.year == 7'd0 && now.mon == 4'd1)); // R6

endmodule

// File: rtl/cmos_nvram.sv
module cmos_nvram #(
   parameter int unsigned NV_BYTES = 32,
   localparam int unsigned AW = $clog2(NV_BYTES)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cpu_we,
   input  logic [AW-1:0] cpu_addr,
   input  logic [7:0]    cpu_wdata,
   output logic [7:0]    cpu_rdata,
   input  logic          lnk_we,
   input  logic [AW-1:0] lnk_waddr,
   input  logic [7:0]    lnk_wdata,
   input  logic [AW-1:0] lnk_raddr,
   output logic [7:0]    lnk_rdata
);
   if ((1 << AW) != NV_BYTES || NV_BYTES < 4) begin : g_bad_size
      $error("cmos_nvram: NV_BYTES must be a power of two, at least 4");
   end

   logic [7:0] mem [NV_BYTES];

   for (genvar i = 0; i < NV_BYTES; i++) begin : g_byte
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            mem[i] <= 8'h00;
         end else if (cpu_we && cpu_addr == AW'(i)) begin
            mem[i] <= cpu_wdata;
         end else if (lnk_we && lnk_waddr == AW'(i)) begin
            mem[i] <= lnk_wdata;
         end
      end
   end

   assign cpu_rdata = mem[cpu_addr];
   assign lnk_rdata = mem[lnk_raddr];

   AST_NV_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!cpu_we && !lnk_we) |=> (cpu_addr != $past(cpu_addr)) || (cpu_rdata == $past(cpu_rdata))); // R7

endmodule

// File: rtl/cmos_serial_link.sv
module cmos_serial_link #(
   parameter int unsigned AW          = 5,
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned LINK_IDLE   = 4096
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          lnk_clk,
   input  logic          lnk_dat_i,
   output logic          lnk_dat_o,
   output logic [AW-1:0] rd_addr,
   input  logic [7:0]    rd_data,
   output logic          wr_en,
   output logic [AW-1:0] wr_addr,
   output logic [7:0]    wr_data
);
   localparam int unsigned HDR_BITS   = 1 + AW;
   localparam int unsigned FRAME_BITS = HDR_BITS + 8;
   localparam int unsigned CNTW       = $clog2(FRAME_BITS + 1);
   localparam int unsigned IW         = $clog2(LINK_IDLE + 1);

   if (SYNC_STAGES < 2 || AW < 2 || LINK_IDLE < 4) begin : g_bad_cfg
      $error("cmos_serial_link: SYNC_STAGES>=2, AW>=2 and LINK_IDLE>=4 required");
   end

   logic [SYNC_STAGES-1:0] s_clk;
   logic [SYNC_STAGES-1:0] s_dat;
   logic                   clk_q;
   logic                   rise;
   logic                   bit_in;

   for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_sync
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            s_clk[g] <= 1'b0;
            s_dat[g] <= 1'b0;
         end else if (g == 0) begin
            s_clk[g] <= lnk_clk;
            s_dat[g] <= lnk_dat_i;
         end else begin
            s_clk[g] <= s_clk[(g > 0) ? g - 1 : 0];
            s_dat[g] <= s_dat[(g > 0) ? g - 1 : 0];
         end
      end
   end

   assign rise   = s_clk[SYNC_STAGES-1] & ~clk_q;
   assign bit_in = s_dat[SYNC_STAGES-1];

   logic [CNTW-1:0] cnt;
   logic [IW-1:0]   idle;
   logic [AW-1:0]   hdr;
   logic            dir_wr;
   logic [AW-1:0]   addr_q;
   logic [7:0]      sh;

   assign rd_addr = {hdr[AW-2:0], bit_in};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         clk_q  <= 1'b0;
         cnt    <= '0;
         idle   <= '0;
         hdr    <= '0;
         dir_wr <= 1'b1;
         addr_q <= '0;
         sh     <= 8'hFF;
         wr_en  <= 1'b0;
      end else begin
         clk_q <= s_clk[SYNC_STAGES-1];
         wr_en <= 1'b0;
         if (rise) begin
            idle <= '0;
            if (cnt < CNTW'(HDR_BITS - 1)) begin
               hdr <= {hdr[AW-2:0], bit_in};
               cnt <= cnt + 1'b1;
            end else if (cnt == CNTW'(HDR_BITS - 1)) begin
               dir_wr <= hdr[AW-1];
               addr_q <= rd_addr;
               sh     <= rd_data;
               cnt    <= cnt + 1'b1;
            end else begin
               sh <= {sh[6:0], bit_in};
               if (cnt == CNTW'(FRAME_BITS - 1)) begin
                  cnt   <= '0;
                  wr_en <= dir_wr;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
         end else if (idle == IW'(LINK_IDLE)) begin
            cnt <= '0;
         end else begin
            idle <= idle + 1'b1;
         end
      end
   end

   assign wr_addr   = addr_q;
   assign wr_data   = sh;
   assign lnk_dat_o = (!dir_wr && cnt >= CNTW'(HDR_BITS)) ? sh[7] : 1'b1;

   AST_LINK_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      cnt < CNTW'(FRAME_BITS)); // R9
   AST_LINK_WE_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> (cnt == '0) && $past(rise)); // R9
   AST_LINK_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      (idle == IW'(LINK_IDLE) && !rise) |=> lnk_dat_o); // R11

endmodule

// File: rtl/cmos_rtc_nv.sv
module cmos_rtc_nv
   import cmos_rtc_pkg::*;
#(
   parameter int unsigned DIV_COUNT    = 1193182,
   parameter int unsigned NV_BYTES     = 32,
   parameter logic [7:0]  NV_BASE      = 8'h10,
   parameter int unsigned SYNC_STAGES  = 2,
   parameter int unsigned LINK_IDLE    = 4096,
   parameter bit          LEAP_EVERY_4 = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       tmr_ref_en,
   input  logic       io_addr,
   input  logic       io_rd,
   input  logic       io_wr,
   input  logic [7:0] io_wdata,
   output logic [7:0] io_rdata,
   input  logic       lnk_clk,
   input  logic       lnk_dat_i,
   output logic       lnk_dat_o
);
   localparam int unsigned AW = $clog2(NV_BYTES);

   if (int'(NV_BASE) + NV_BYTES > 256 || NV_BASE <= IDX_YEAR) begin : g_bad_window
      $error("cmos_rtc_nv: RAM window overlaps time registers or exceeds index range");
   end

   logic          tick;
   rtc_time_t     now;
   time_field_e   fld;
   logic [7:0]    idx;
   logic          in_nv;
   logic [AW-1:0] nv_off;
   logic          cpu_nv_we;
   logic [7:0]    cpu_nv_rdata;
   logic [AW-1:0] lnk_raddr;
   logic [7:0]    lnk_rdata;
   logic          lnk_we;
   logic [AW-1:0] lnk_waddr;
   logic [7:0]    lnk_wdata;
   logic [7:0]    data_mux;

   cmos_tick_div #(.DIV_COUNT(DIV_COUNT)) u_div (
      .clk(clk), .rst_n(rst_n), .ref_en(tmr_ref_en), .tick(tick)
   );

   cmos_time_keeper #(.LEAP_EVERY_4(LEAP_EVERY_4)) u_time (
      .clk(clk), .rst_n(rst_n), .tick(tick), .wr_sel(fld), .wr_val(io_wdata), .now(now)
   );

   cmos_nvram #(.NV_BYTES(NV_BYTES)) u_nv (
      .clk(clk), .rst_n(rst_n),
      .cpu_we(cpu_nv_we), .cpu_addr(nv_off), .cpu_wdata(io_wdata), .cpu_rdata(cpu_nv_rdata),
      .lnk_we(lnk_we), .lnk_waddr(lnk_waddr), .lnk_wdata(lnk_wdata),
      .lnk_raddr(lnk_raddr), .lnk_rdata(lnk_rdata)
   );

   cmos_serial_link #(.AW(AW), .SYNC_STAGES(SYNC_STAGES), .LINK_IDLE(LINK_IDLE)) u_link (
      .clk(clk), .rst_n(rst_n), .lnk_clk(lnk_clk), .lnk_dat_i(lnk_dat_i), .lnk_dat_o(lnk_dat_o),
      .rd_addr(lnk_raddr), .rd_data(lnk_rdata),
      .wr_en(lnk_we), .wr_addr(lnk_waddr), .wr_data(lnk_wdata)
   );

   assign in_nv  = ({1'b0, idx} >= {1'b0, NV_BASE}) && ({1'b0, idx} < (9'(NV_BASE) + 9'(NV_BYTES)));
   assign nv_off = idx[AW-1:0] - NV_BASE[AW-1:0];

   always_comb begin
      fld       = FLD_NONE;
      cpu_nv_we = 1'b0;
      if (io_wr && io_addr) begin
         if (in_nv) begin
            cpu_nv_we = 1'b1;
         end else begin
            case (idx)
               IDX_SEC:  fld = FLD_SEC;
               IDX_MIN:  fld = FLD_MIN;
               IDX_HOUR: fld = FLD_HOUR;
               IDX_DAY:  fld = FLD_DAY;
               IDX_MON:  fld = FLD_MON;
               IDX_YEAR: fld = FLD_YEAR;
               default:  fld = FLD_NONE;
            endcase
         end
      end
   end

   always_comb begin
      if (in_nv) begin
         data_mux = cpu_nv_rdata;
      end else begin
         case (idx)
            IDX_SEC:  data_mux = {2'b00, now.sec};
            IDX_MIN:  data_mux = {2'b00, now.min};
            IDX_HOUR: data_mux = {3'b000, now.hour};
            IDX_DAY:  data_mux = {3'b000, now.day};
            IDX_MON:  data_mux = {4'b0000, now.mon};
            IDX_YEAR: data_mux = {1'b0, now.year};
            default:  data_mux = 8'h00;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         idx      <= 8'h00;
         io_rdata <= 8'h00;
      end else begin
         if (io_wr && !io_addr) idx <= io_wdata;
         if (io_rd) io_rdata <= io_addr ? data_mux : idx;
      end
   end

   AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !io_rd |=> $stable(io_rdata)); // R2
   AST_UNMAPPED_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (io_wr && io_addr && !in_nv && idx != IDX_SEC && idx != IDX_MIN && idx != IDX_HOUR
       && idx != IDX_DAY && idx != IDX_MON && idx != IDX_YEAR && !tick) |=> $stable(now)); // R8

endmodule

// File: tb/sim_cmos_rtc_nv.sv
module sim_cmos_rtc_nv;
   localparam int DIV  = 4;
   localparam int HALF = 8;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tmr_ref_en = 1'b0;
   logic       io_addr = 1'b0;
   logic       io_rd = 1'b0;
   logic       io_wr = 1'b0;
   logic [7:0] io_wdata = 8'h00;
   logic [7:0] io_rdata;
   logic       lnk_clk = 1'b0;
   logic       lnk_dat_i = 1'b0;
   logic       lnk_dat_o;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 0;

   int m_sec, m_min, m_hr, m_day, m_mon, m_yr, m_div;

   always #10 clk = ~clk;

   cmos_rtc_nv #(.DIV_COUNT(DIV), .LINK_IDLE(40)) u0 (
      .clk(clk), .rst_n(rst_n), .tmr_ref_en(tmr_ref_en),
      .io_addr(io_addr), .io_rd(io_rd), .io_wr(io_wr), .io_wdata(io_wdata), .io_rdata(io_rdata),
      .lnk_clk(lnk_clk), .lnk_dat_i(lnk_dat_i), .lnk_dat_o(lnk_dat_o)
   );

   function automatic int dim(input int mo, input int yr);
      if (mo == 2) return (yr % 4 == 0) ? 29 : 28;
      if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
      return 31;
   endfunction

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: got 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic model_sec();
      m_sec++;
      if (m_sec == 60) begin
         m_sec = 0; m_min++;
         if (m_min == 60) begin
            m_min = 0; m_hr++;
            if (m_hr == 24) begin
               m_hr = 0; m_day++;
               if (m_day > dim(m_mon, m_yr)) begin
                  m_day = 1; m_mon++;
                  if (m_mon == 13) begin
                     m_mon = 1; m_yr = (m_yr + 1) % 100;
                  end
               end
            end
         end
      end
   endtask

   task automatic io_write(input logic a, input logic [7:0] d);
      @(negedge clk);
      io_addr = a; io_wdata = d; io_wr = 1'b1;
      @(negedge clk);
      io_wr = 1'b0;
   endtask

   task automatic io_read(input logic a, output logic [7:0] d);
      @(negedge clk);
      io_addr = a; io_rd = 1'b1;
      @(negedge clk);
      io_rd = 1'b0;
      d = io_rdata;
   endtask

   task automatic reg_wr(input logic [7:0] ix, input logic [7:0] d);
      io_write(1'b0, ix);
      io_write(1'b1, d);
   endtask

   task automatic reg_rd(input logic [7:0] ix, output logic [7:0] d);
      io_write(1'b0, ix);
      io_read(1'b1, d);
   endtask

   task automatic set_time(input int h, input int mi, input int s, input int d, input int mo, input int y);
      reg_wr(8'h00, 8'(s)); reg_wr(8'h02, 8'(mi)); reg_wr(8'h04, 8'(h));
      reg_wr(8'h07, 8'(d)); reg_wr(8'h08, 8'(mo)); reg_wr(8'h09, 8'(y));
      m_sec = s; m_min = mi; m_hr = h; m_day = d; m_mon = mo; m_yr = y;
   endtask

   task automatic strobes(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         tmr_ref_en = 1'b1;
         m_div++;
         if (m_div == DIV) begin
            m_div = 0;
            model_sec();
         end
      end
      @(negedge clk);
      tmr_ref_en = 1'b0;
      repeat (3) @(negedge clk);
   endtask

   task automatic check_time(input string req);
      logic [7:0] v;
      reg_rd(8'h00, v); chk({req, " sec"}, v, m_sec);
      reg_rd(8'h02, v); chk({req, " min"}, v, m_min);
      reg_rd(8'h04, v); chk({req, " hour"}, v, m_hr);
      reg_rd(8'h07, v); chk({req, " day"}, v, m_day);
      reg_rd(8'h08, v); chk({req, " month"}, v, m_mon);
      reg_rd(8'h09, v); chk({req, " year"}, v, m_yr);
   endtask

   task automatic link_bit(input logic b);
      lnk_clk = 1'b0; lnk_dat_i = b;
      repeat (HALF) @(negedge clk);
      lnk_clk = 1'b1;
      repeat (HALF) @(negedge clk);
   endtask

   task automatic link_hdr(input logic dw, input logic [4:0] a);
      link_bit(dw);
      for (int i = 4; i >= 0; i--) link_bit(a[i]);
   endtask

   task automatic link_write(input logic [4:0] a, input logic [7:0] d);
      link_hdr(1'b1, a);
      for (int i = 7; i >= 0; i--) link_bit(d[i]);
      lnk_clk = 1'b0;
      repeat (HALF) @(negedge clk);
   endtask

   task automatic link_read(input logic [4:0] a, output logic [7:0] d);
      link_hdr(1'b0, a);
      for (int i = 7; i >= 0; i--) begin
         lnk_clk = 1'b0;
         repeat (HALF) @(negedge clk);
         d[i] = lnk_dat_o;
         lnk_clk = 1'b1;
         repeat (HALF) @(negedge clk);
      end
      lnk_clk = 1'b0;
      repeat (HALF) @(negedge clk);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      logic [7:0] v;
      logic [7:0] nv_img [32];
      void'($urandom(32'd7151));
      m_sec = 0; m_min = 0; m_hr = 0; m_day = 1; m_mon = 1; m_yr = 0; m_div = 0;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      // R12 reset state
      io_read(1'b0, v); chk("R12 index", v, 0);
      check_time("R12");
      reg_rd(8'h1F, v); chk("R12 nvram", v, 0);
      chk("R10 idle out", lnk_dat_o, 1);

      // R1 index port
      io_write(1'b0, 8'h2A); io_read(1'b0, v); chk("R1 index readback", v, 8'h2A);

      // R2 load / read
      set_time(13, 45, 7, 12, 6, 37);
      check_time("R2");

      // R3 divider exactness
      strobes(DIV - 1); check_time("R3 before tick");
      strobes(1); check_time("R3 at tick");

      // R4 hour and day carry
      set_time(23, 59, 58, 10, 3, 21); m_div = m_div;
      strobes(2 * DIV); check_time("R4 carry");

      // R5 leap and common February, 30-day month
      set_time(23, 59, 59, 28, 2, 4);  strobes(DIV); check_time("R5 leap feb28");
      set_time(23, 59, 59, 29, 2, 4);  strobes(DIV); check_time("R5 leap feb29");
      set_time(23, 59, 59, 28, 2, 3);  strobes(DIV); check_time("R5 common feb28");
      set_time(23, 59, 59, 30, 4, 50); strobes(DIV); check_time("R5 april30");

      // R6 century wrap
      set_time(23, 59, 59, 31, 12, 99); strobes(DIV); check_time("R6 year wrap");

      // R7 nvram through data port, edges of window
      reg_wr(8'h10, 8'h5A); reg_wr(8'h2F, 8'hC3);
      reg_rd(8'h10, v); chk("R7 first byte", v, 8'h5A);
      reg_rd(8'h2F, v); chk("R7 last byte", v, 8'hC3);

      // R8 unmapped
      reg_wr(8'h0F, 8'h77); reg_rd(8'h0F, v); chk("R8 below window", v, 0);
      reg_wr(8'h30, 8'h66); reg_rd(8'h30, v); chk("R8 above window", v, 0);
      reg_wr(8'h05, 8'h11); reg_rd(8'h05, v); chk("R8 gap index", v, 0);
      reg_rd(8'h10, v); chk("R8 no alias low", v, 8'h5A);
      reg_rd(8'h2F, v); chk("R8 no alias high", v, 8'hC3);
      check_time("R8 time untouched");

      // R9 link write, read back on data port
      link_write(5'd3, 8'hA5);
      reg_rd(8'h13, v); chk("R9 link store", v, 8'hA5);
      link_write(5'd31, 8'h3C);
      reg_rd(8'h2F, v); chk("R9 link store top", v, 8'h3C);

      // R10 link read of a CPU-written byte
      reg_wr(8'h18, 8'h96);
      link_read(5'd8, v); chk("R10 link read", v, 8'h96);
      chk("R10 idle after read", lnk_dat_o, 1);

      // R11 aborted frame then a clean one
      link_bit(1'b1); link_bit(1'b0); link_bit(1'b1);
      lnk_clk = 1'b0;
      repeat (60) @(negedge clk);
      link_write(5'd1, 8'h42);
      reg_rd(8'h11, v); chk("R11 after abort", v, 8'h42);
      reg_rd(8'h15, v); chk("R11 no stray write", v, 0);

      // random mix: time advance and nvram round trips
      for (int k = 0; k < 32; k++) nv_img[k] = 8'h00;
      for (int k = 0; k < 32; k++) begin
         logic [7:0] rv;
         reg_rd(8'(8'h10 + k), rv);
         nv_img[k] = rv;
      end
      for (int it = 0; it < 16; it++) begin
         int mo, yr, dd;
         logic [4:0] a;
         logic [7:0] d;
         mo = 1 + int'($urandom % 12);
         yr = int'($urandom % 100);
         dd = 1 + int'($urandom % dim(mo, yr));
         set_time(int'($urandom % 24), int'($urandom % 60), int'($urandom % 60), dd, mo, yr);
         strobes(int'($urandom % (DIV * 70)));
         check_time("R3 random");
         a = 5'($urandom); d = 8'($urandom);
         if (it % 2 == 0) begin
            reg_wr(8'(8'h10 + a), d);
            link_read(a, v); chk("R10 random link read", v, d);
         end else begin
            link_write(a, d);
            reg_rd(8'(8'h10 + a), v); chk("R9 random link write", v, d);
         end
         nv_img[a] = d;
      end
      reg_rd(8'h13, v); chk("R7 image", v, nv_img[3]);

      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
   end
endmodule